// File: doc/BRIEF.md
# Buffer Event Interrupt Controller

This block holds the interrupt-enable register and the buffer-event status register of a network controller's buffer manager. The host reaches both through a simple register port: address, write data, a write strobe, a read strobe and combinational read data. The data path feeds it one-cycle pulses when a received frame has finished its DMA transfer, when the transmitter can accept a frame, when a transmit underrun occurs and when a received frame is lost. It also watches received bytes and transmit collisions and derives two more events from them: an early-receive event at the 128th byte of a frame, and a collision-counter overflow when its 10-bit counter moves from 0x1FF to 0x200.

Every event is latched into a sticky status bit. A read of the event register returns the bits and clears them. Each latched bit is masked by its enable, and the results are ORed into one registered, active-high interrupt line. The host can also raise an interrupt itself by writing a one to a write-only trigger bit. An underrun also produces a one-cycle abort pulse toward the transmitter, so the current frame is given up until the host asks again. When either receive-DMA mode input is set, the early-receive enable is forced off.

Top module: `bufevt_irq_ctrl`

## Requirements
- R1: The enable register is at address 0x010A. Its bits 5:0 always read 6'b001011 and writes to them have no effect. Bits 15:13 read 0.
- R2: Enable bits 12:7 are written from the matching write-data bits and read back at the same positions: 7 receive DMA done, 8 transmit ready, 9 underrun, 10 receive miss, 11 early receive, 12 collision overflow.
- R3: Writing 1 to bit 6 of the enable register sets event bit 6. Bit 6 always reads back 0. Event bit 6 takes part in the interrupt without any enable.
- R4: The event register is at address 0x010C. Each event sets the event bit at the same position as its enable bit. Bits 5:0 and 15:13 read 0.
- R5: Event bits are sticky. A read of the event register (strobe high with the address at 0x010C) returns the bits before the clear and then clears them. An event in the same cycle as the read stays set.
- R6: The interrupt output is high in the cycle after the one in which (event AND enable) over bits 12:6 is non-zero, and low otherwise. An event whose enable is 0 does not raise it.
- R7: An underrun pulse gives a one-cycle tx_abort pulse in the next cycle.
- R8: A frame-start pulse clears the byte count; in that cycle a byte strobe is not counted. The early-receive event fires once per frame, on the byte strobe that brings the count to 128. Later bytes of the same frame do not fire it again.
- R9: The collision counter is 10 bits wide. It counts tx_coll only while tx_active is high and wraps from 0x3FF to 0. The overflow event fires only on the step from 0x1FF to 0x200.
- R10: While cfg_auto_rx_dma or cfg_rx_dma_only is high, enable bit 11 reads 0, blocks the early-receive interrupt and is cleared in storage. The event itself still latches.
- R11: Reset clears all enable bits, event bits, the byte and collision counters, irq and tx_abort. The ID bits still read 6'b001011.
- R12: Writes to any other address change nothing. Reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Write strobe |
| reg_re | input | 1 | Read strobe (clears the event register when it is addressed) |
| reg_rdata | output | 16 | Read data for reg_addr |
| cfg_auto_rx_dma | input | 1 | Automatic receive-DMA mode |
| cfg_rx_dma_only | input | 1 | Receive-DMA-only mode |
| ev_rx_dma_done | input | 1 | Pulse: received frame DMA complete |
| ev_tx_ready | input | 1 | Pulse: ready to accept a transmit frame |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_rx_miss | input | 1 | Pulse: received frame lost |
| rx_frame_start | input | 1 | Pulse: a new received frame begins |
| rx_byte_stb | input | 1 | One received byte |
| tx_active | input | 1 | A frame is being transmitted |
| tx_coll | input | 1 | Collision indication |
| irq | output | 1 | Registered interrupt request, active high |
| tx_abort | output | 1 | One-cycle pulse: abandon the current transmit frame |

## Verification
The masking and latching logic is driven with a long seeded random mix of event pulses, enable writes, clearing reads and stray addresses. A reference model in the bench predicts the read data, irq and tx_abort every cycle, so wrong bit placement, lost stickiness and missing masks all show up. Directed cases cover the edges that random traffic rarely reaches. For the byte counter these are the 127th against the 128th byte and bytes after the 128th. For the collision counter they are the 0x1FF crossing, the wrap back to zero, and collisions while idle. The directed cases also cover a read that coincides with an event, the software trigger with every enable off, and each DMA mode input locking out the early-receive enable.

// File: rtl/bufevt_pkg.sv
`timescale 1ns/1ps
package bufevt_pkg;

  localparam int BIT_SW    = 6;
  localparam int BIT_RXDMA = 7;
  localparam int BIT_TXRDY = 8;
  localparam int BIT_UNDER = 9;
  localparam int BIT_MISS  = 10;
  localparam int BIT_EARLY = 11;
  localparam int BIT_COLL  = 12;

  localparam logic [5:0] ENABLE_ID = 6'b001011;

  typedef logic [12:6] evt_t;
  typedef logic [12:7] en_t;

  // mask with the software trigger always enabled
  function automatic evt_t irq_mask(en_t en);
    return {en, 1'b1};
  endfunction

  function automatic logic irq_reduce(evt_t evt, en_t en);
    return |(evt & irq_mask(en));
  endfunction

  function automatic logic [15:0] pack_enable(en_t en);
    logic [15:0] w;
    w        = '0;
    w[5:0]   = ENABLE_ID;
    w[12:7]  = en;
    return w;
  endfunction

  function automatic logic [15:0] pack_event(evt_t evt);
    logic [15:0] w;
    w       = '0;
    w[12:6] = evt;
    return w;
  endfunction

endpackage

// File: rtl/bufevt_enable_reg.sv
`timescale 1ns/1ps
module bufevt_enable_reg
  import bufevt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] EN_OFS = 16'h010A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [12:6]       wbits,
  input  logic              we,
  input  logic              dma_lock,
  output en_t               en_eff,
  output logic              sw_pulse
);

  en_t  en_q;
  en_t  en_d;
  logic hit;

  assign hit      = we && (addr == EN_OFS);
  assign sw_pulse = hit && wbits[BIT_SW];

  always_comb begin
    en_d = en_q;
    if (hit) en_d = wbits[12:7];
    if (dma_lock) en_d[BIT_EARLY] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  always_comb begin
    en_eff = en_q;
    if (dma_lock) en_eff[BIT_EARLY] = 1'b0;
  end

  // R10: the stored early-receive enable is gone after a locked cycle
  a_r10_lock_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dma_lock) |-> !en_q[BIT_EARLY]);

endmodule

// File: rtl/bufevt_early_rx.sv
`timescale 1ns/1ps
module bufevt_early_rx #(
  parameter int EARLY_BYTES = 128,
  localparam int CNT_W = $clog2(EARLY_BYTES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  input  logic byte_stb,
  output logic fire
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(EARLY_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(EARLY_BYTES);

  logic [CNT_W-1:0] cnt;

  assign fire = byte_stb && !frame_start && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt <= '0;
    else if (frame_start)               cnt <= '0;
    else if (byte_stb && cnt != FULL)   cnt <= cnt + 1'b1;
  end

  // R8: the event coincides with reaching the threshold
  a_r8_count: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == FULL));
  // R8: once saturated no further event in this frame
  a_r8_once: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL) |-> !fire);

endmodule

// File: rtl/bufevt_coll_cnt.sv
`timescale 1ns/1ps
module bufevt_coll_cnt #(
  parameter int COLL_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic tx_coll,
  output logic ovf
);

  localparam logic [COLL_W-1:0] CROSS = COLL_W'((1 << (COLL_W - 1)) - 1);

  logic [COLL_W-1:0] cnt;
  logic              inc;

  assign inc = tx_coll && tx_active;
  assign ovf = inc && (cnt == CROSS);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  // R9: the overflow event lands the counter on the half-range value
  a_r9_cross: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> (cnt == CROSS + 1'b1));
  // R9: no counting while idle
  a_r9_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> $stable(cnt));

endmodule

// File: rtl/bufevt_event_reg.sv
`timescale 1ns/1ps
module bufevt_event_reg
  import bufevt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  evt_t set_vec,
  input  logic clr,
  output evt_t evt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (clr ? '0 : evt_q) | set_vec;
  end

  // R5: without a clearing read no bit is lost
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
  // R5: an event in the clearing cycle survives
  a_r5_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_vec[BIT_MISS]) |=> evt_q[BIT_MISS]);

endmodule

// File: rtl/bufevt_irq_ctrl.sv
`timescale 1ns/1ps
module bufevt_irq_ctrl
  import bufevt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int EARLY_BYTES = 128,
  parameter int COLL_W      = 10,
  parameter logic [ADDR_W-1:0] EN_OFS = 16'h010A,
  parameter logic [ADDR_W-1:0] EV_OFS = 16'h010C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_we,
  input  logic              reg_re,
  output logic [15:0]       reg_rdata,
  input  logic              cfg_auto_rx_dma,
  input  logic              cfg_rx_dma_only,
  input  logic              ev_rx_dma_done,
  input  logic              ev_tx_ready,
  input  logic              ev_tx_underrun,
  input  logic              ev_rx_miss,
  input  logic              rx_frame_start,
  input  logic              rx_byte_stb,
  input  logic              tx_active,
  input  logic              tx_coll,
  output logic              irq,
  output logic              tx_abort
);

  en_t  en_eff;
  evt_t evt_q;
  evt_t set_vec;
  logic sw_pulse;
  logic early_fire;
  logic coll_ovf;
  logic dma_lock;
  logic evt_clr;
  logic unused_wbits;

  assign dma_lock     = cfg_auto_rx_dma || cfg_rx_dma_only;
  assign evt_clr      = reg_re && (reg_addr == EV_OFS);
  assign unused_wbits = ^{reg_wdata[15:13], reg_wdata[5:0]};

  bufevt_enable_reg #(.ADDR_W(ADDR_W), .EN_OFS(EN_OFS)) u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (reg_addr),
    .wbits    (reg_wdata[12:6]),
    .we       (reg_we),
    .dma_lock (dma_lock),
    .en_eff   (en_eff),
    .sw_pulse (sw_pulse)
  );

  bufevt_early_rx #(.EARLY_BYTES(EARLY_BYTES)) u_early (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (rx_frame_start),
    .byte_stb    (rx_byte_stb),
    .fire        (early_fire)
  );

  bufevt_coll_cnt #(.COLL_W(COLL_W)) u_coll (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .tx_coll   (tx_coll),
    .ovf       (coll_ovf)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[BIT_SW]    = sw_pulse;
    set_vec[BIT_RXDMA] = ev_rx_dma_done;
    set_vec[BIT_TXRDY] = ev_tx_ready;
    set_vec[BIT_UNDER] = ev_tx_underrun;
    set_vec[BIT_MISS]  = ev_rx_miss;
    set_vec[BIT_EARLY] = early_fire;
    set_vec[BIT_COLL]  = coll_ovf;
  end

  bufevt_event_reg u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr     (evt_clr),
    .evt_q   (evt_q)
  );

  always_comb begin
    if (reg_addr == EN_OFS)      reg_rdata = pack_enable(en_eff);
    else if (reg_addr == EV_OFS) reg_rdata = pack_event(evt_q);
    else                         reg_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      tx_abort <= 1'b0;
    end else begin
      irq      <= irq_reduce(evt_q, en_eff);
      tx_abort <= ev_tx_underrun;
    end
  end

  // R1: the identification bits are always present
  a_r1_id: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == EN_OFS) |-> (reg_rdata[5:0] == ENABLE_ID));
  // R3: a trigger write always latches the software event
  a_r3_sw_latch: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pulse |=> evt_q[BIT_SW]);
  // R6: nothing pending means no interrupt next cycle
  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_q == '0) |=> !irq);
  // R7: underrun gives the abort pulse
  a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underrun |=> tx_abort);
  // R7: the abort pulse lasts one cycle without a new underrun
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_tx_underrun |=> !tx_abort);

endmodule

// File: tb/bufevt_irq_ctrl_test.sv
`timescale 1ns/1ps
module bufevt_irq_ctrl_test;

  localparam logic [15:0] EN = 16'h010A;
  localparam logic [15:0] EV = 16'h010C;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] reg_addr, reg_wdata, reg_rdata;
  logic        reg_we, reg_re;
  logic        cfg_a, cfg_b;
  logic        ev_rxdma, ev_txrdy, ev_under, ev_miss;
  logic        fstart, bstb, txact, coll;
  logic        irq, tx_abort;

  int tot = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [12:6] m_evt;
  logic [12:7] m_en;
  logic        m_irq, m_abort;
  int          m_bcnt, m_ccnt;
  logic [15:0] last_rd;

  bufevt_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .cfg_auto_rx_dma(cfg_a), .cfg_rx_dma_only(cfg_b),
    .ev_rx_dma_done(ev_rxdma), .ev_tx_ready(ev_txrdy),
    .ev_tx_underrun(ev_under), .ev_rx_miss(ev_miss),
    .rx_frame_start(fstart), .rx_byte_stb(bstb),
    .tx_active(txact), .tx_coll(coll), .irq(irq), .tx_abort(tx_abort)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [12:7] eff_en(logic [12:7] en, logic lock);
    logic [12:7] e;
    e = en;
    if (lock) e[11] = 1'b0;
    return e;
  endfunction

  function automatic logic [15:0] exp_read(logic [15:0] a, logic [12:7] en, logic [12:6] ev);
    if (a == EN) return {3'b000, en, 1'b0, 6'b001011};
    if (a == EV) return {3'b000, ev, 6'b000000};
    return 16'h0000;
  endfunction

  task automatic model_reset();
    m_evt = '0; m_en = '0; m_irq = 0; m_abort = 0; m_bcnt = 0; m_ccnt = 0;
  endtask

  task automatic clear_pulses();
    reg_we = 0; reg_re = 0; ev_rxdma = 0; ev_txrdy = 0; ev_under = 0;
    ev_miss = 0; fstart = 0; bstb = 0; coll = 0;
  endtask

  // one clock: check read data, predict next state, check registered outputs
  task automatic tick();
    logic [12:7] ee;
    logic [12:6] setv;
    logic        lock, early, covf, nirq;
    string       tg;
    #1;
    lock = cfg_a | cfg_b;
    ee = eff_en(m_en, lock);
    tg = (reg_addr == EN) ? "R1 enable read" : (reg_addr == EV) ? "R4 event read" : "R12 other read";
    last_rd = reg_rdata;
    check(tg, reg_rdata, exp_read(reg_addr, ee, m_evt));
    early = bstb && !fstart && (m_bcnt == 127);
    covf  = coll && txact && (m_ccnt == 511);
    setv = {covf, early, ev_miss, ev_under, ev_txrdy, ev_rxdma,
            (reg_we && reg_addr == EN && reg_wdata[6])};
    nirq = |(m_evt & {ee, 1'b1});
    @(posedge clk);
    m_irq   = nirq;
    m_abort = ev_under;
    m_evt   = ((reg_re && reg_addr == EV) ? 7'b0 : m_evt) | setv;
    if (reg_we && reg_addr == EN) m_en = reg_wdata[12:7];
    if (lock) m_en[11] = 1'b0;
    if (fstart) m_bcnt = 0;
    else if (bstb && m_bcnt < 128) m_bcnt++;
    if (coll && txact) m_ccnt = (m_ccnt + 1) % 1024;
    @(negedge clk);
    check("R6 irq", {15'b0, irq}, {15'b0, m_irq});
    check("R7 tx_abort", {15'b0, tx_abort}, {15'b0, m_abort});
    clear_pulses();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; tick();
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    reg_addr = a; reg_re = 1; tick(); d = last_rd;
  endtask

  task automatic bytes(input int n);
    for (int i = 0; i < n; i++) begin bstb = 1; tick(); end
  endtask

  task automatic colls(input int n);
    for (int i = 0; i < n; i++) begin coll = 1; tick(); end
  endtask

  task automatic do_reset();
    @(negedge clk);
    clear_pulses();
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tot++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", tot, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int seed;
    seed = $urandom(32'd61409);
    reg_addr = 0; reg_wdata = 0; cfg_a = 0; cfg_b = 0; txact = 0;
    clear_pulses();
    model_reset();
    do_reset();

    // R11: reset state
    check("R11 irq after reset", {15'b0, irq}, 16'h0);
    rd(EN, d); check("R11 enable after reset", d, 16'h000B);
    rd(EV, d); check("R11 events after reset", d, 16'h0000);

    // R2: enable bits read back
    wr(EN, 16'h1F80);
    rd(EN, d); check("R2 enable readback", d, 16'h1F8B);

    // R3: software trigger with all enables off
    wr(EN, 16'h0000);
    wr(EN, 16'h0040);
    rd(EN, d); check("R3 trigger reads 0", d, 16'h000B);
    check("R3 irq without enables", {15'b0, irq}, 16'h1);
    rd(EV, d); check("R3 software event bit", d, 16'h0040);
    tick(); tick();
    check("R3 irq drops after clear", {15'b0, irq}, 16'h0);

    // R4/R6: masked event latches but no irq
    ev_rxdma = 1; tick(); tick();
    check("R6 masked event no irq", {15'b0, irq}, 16'h0);
    rd(EV, d); check("R4 receive DMA bit", d, 16'h0080);
    ev_txrdy = 1; tick();
    rd(EV, d); check("R4 transmit ready bit", d, 16'h0100);

    // R5: event in the clearing cycle survives
    reg_addr = EV; reg_re = 1; ev_miss = 1; tick();
    check("R5 read returns pre-clear", last_rd, 16'h0000);
    rd(EV, d); check("R5 same-cycle event kept", d, 16'h0400);

    // R7: underrun abort
    wr(EN, 16'h0200);
    ev_under = 1; tick();
    check("R7 abort pulse", {15'b0, tx_abort}, 16'h1);
    tick();
    check("R7 abort one cycle", {15'b0, tx_abort}, 16'h0);
    check("R6 enabled underrun irq", {15'b0, irq}, 16'h1);
    rd(EV, d); check("R4 underrun bit", d, 16'h0200);

    // R8: early receive
    wr(EN, 16'h0800);
    fstart = 1; tick();
    bytes(127);
    rd(EV, d); check("R8 no event at 127", d, 16'h0000);
    bytes(1);
    rd(EV, d); check("R8 event at 128", d, 16'h0800);
    bytes(50);
    rd(EV, d); check("R8 once per frame", d, 16'h0000);
    fstart = 1; bstb = 1; tick();
    bytes(128);
    rd(EV, d); check("R8 next frame", d, 16'h0800);

    // R10: DMA modes lock out the early enable
    cfg_a = 1;
    wr(EN, 16'h0800);
    rd(EN, d); check("R10 auto DMA forces 0", d, 16'h000B);
    fstart = 1; tick();
    bytes(128);
    tick(); tick();
    check("R10 no early irq", {15'b0, irq}, 16'h0);
    rd(EV, d); check("R10 event still latched", d, 16'h0800);
    cfg_a = 0;
    rd(EN, d); check("R10 stored enable cleared", d, 16'h000B);
    cfg_b = 1;
    wr(EN, 16'h0880);
    rd(EN, d); check("R10 DMA-only forces 0", d, 16'h008B);
    cfg_b = 0;

    // R9: collision counter
    wr(EN, 16'h1000);
    txact = 0; colls(100);
    rd(EV, d); check("R9 idle collisions ignored", d, 16'h0000);
    txact = 1; colls(511);
    rd(EV, d); check("R9 no event at 1FF", d, 16'h0000);
    colls(1);
    rd(EV, d); check("R9 crossing event", d, 16'h1000);
    colls(511);
    colls(1);
    rd(EV, d); check("R9 wrap no event", d, 16'h0000);
    colls(511);
    colls(1);
    rd(EV, d); check("R9 second crossing", d, 16'h1000);
    txact = 0;

    // R12 and R1: stray and constant-field writes
    wr(EN, 16'h0180);
    wr(16'h0100, 16'hFFFF);
    rd(EN, d); check("R12 stray write ignored", d, 16'h018B);
    rd(16'h0100, d); check("R12 stray read zero", d, 16'h0000);
    wr(EN, 16'hE03F);
    rd(EN, d); check("R1 ID bits fixed", d, 16'h000B);

    // R11: reset mid-run
    ev_miss = 1; ev_rxdma = 1; tick();
    wr(EN, 16'h1F80);
    do_reset();
    rd(EV, d); check("R11 events cleared", d, 16'h0000);
    rd(EN, d); check("R11 enables cleared", d, 16'h000B);

    // seeded random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom;
      reg_we = (r % 8 == 0);
      reg_re = ((r >> 3) % 4 == 0);
      case ((r >> 5) % 4)
        0: reg_addr = EN;
        1: reg_addr = EV;
        2: reg_addr = 16'h0100;
        default: reg_addr = 16'($urandom);
      endcase
      reg_wdata = 16'($urandom);
      ev_rxdma = ($urandom % 8 == 0);
      ev_txrdy = ($urandom % 8 == 0);
      ev_under = ($urandom % 8 == 0);
      ev_miss  = ($urandom % 8 == 0);
      fstart   = ($urandom % 64 == 0);
      bstb     = ($urandom % 2 == 0);
      coll     = ($urandom % 2 == 0);
      if ($urandom % 32 == 0) txact = ~txact;
      if ($urandom % 64 == 0) cfg_a = ~cfg_a;
      if ($urandom % 64 == 0) cfg_b = ~cfg_b;
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule